// File: doc/BRIEF.md
# Full-Speed USB Receive Deserializer

This block turns a sampled full-speed USB line into bytes. Once per bit time a strobe marks a valid sample of the differential pair. The block reports the raw line condition and decodes the NRZI stream. It waits for the end of a SYNC pattern, then removes stuffed zeros and collects bytes least-significant bit first. Each finished byte is presented on a parallel bus with a one-clock valid pulse.

Framing is reported with a packet-active flag and an error flag. A packet ends cleanly with an end-of-packet sequence on a byte boundary. A stuffing violation, a misplaced single-ended zero or a malformed end-of-packet raises the error flag for one bit time. The block then either drops out of the packet at once or keeps the packet flag raised until the line shows a single-ended zero. In both cases it waits for an idle J before hunting for SYNC again. Recovering the bit clock and the analog front end are handled by other logic.

Top module: `usb_fs_rx_deser`

## Requirements
- R1: On each strobe the pair {line_dm, line_dp} is registered onto line_state one clock later, with 00 meaning SE0, 01 meaning J, 10 meaning K and 11 meaning SE1. The reset value is 01.
- R2: A decoded bit is 1 when the line_dp level of a J/K sample equals the previous J/K level and 0 when it differs. An SE0 or SE1 sample resets the previous level to J.
- R3: While hunting, rx_active rises one clock after the strobe that completes four decoded bits 0,0,0,1 (oldest first) from J/K samples. An SE0 or SE1 between them cancels the match.
- R4: Payload bits are packed least-significant bit first. One clock after the strobe carrying the eighth bit of a byte, rx_data shows the byte and rx_valid is high for exactly one clock.
- R5: After six consecutive decoded 1s, where the final 1 of SYNC counts, a following 0 is discarded. It contributes no payload bit and restarts the run count.
- R6: A decoded 1 in the position of a stuffed zero raises rx_error one clock after its strobe and leaves rx_active unchanged.
- R7: An SE0 on a byte boundary drops rx_active one clock after its strobe. A byte boundary includes a pending stuffed-zero position. After at least two SE0 samples, a J returns the block to hunting without any error.
- R8: While in a packet, an SE0 in the middle of a byte raises rx_error, and so does an SE1 at any point.
- R9: During end-of-packet, a J after only one SE0, or a K or SE1, raises rx_error while rx_active stays low.
- R10: rx_error lasts exactly one bit time. If rx_active was low, or the next sample is SE0, rx_active is low after that sample. Otherwise rx_active stays high until an SE0 sample. Either way the block then ignores the line until a J is sampled.
- R11: rx_valid is never high while rx_active is low.
- R12: After reset, rx_active, rx_valid and rx_error are 0 and rx_data is 00.
- R13: In a clock without a strobe, line_state, rx_data, rx_active and rx_error keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-clock strobe marking a valid bit sample |
| line_dp | input | 1 | Sampled D+ level |
| line_dm | input | 1 | Sampled D- level |
| line_state | output | 2 | Registered {D-, D+} line condition |
| rx_data | output | 8 | Last completed byte |
| rx_active | output | 1 | Inside a packet (after SYNC, before EOP or abort) |
| rx_valid | output | 1 | One-clock pulse when rx_data holds a new byte |
| rx_error | output | 1 | Receive error, one bit time long |

## Verification
Two functions can fall on the same strobe. The strobe that completes a byte can also push the run of 1s to six, so the valid pulse and an armed stuffed-zero position start together. The next sample is then either a discarded zero or the first SE0 of an end-of-packet, and both must count as a byte boundary. The bench sends bytes ending in six 1s, once with the stuffed zero and once with the SE0 placed directly in the stuff slot. A behavioural reference model runs alongside and is compared on every clock. It judges that the byte is delivered once, with no error, and that rx_active falls on the SE0 strobe.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_e;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SYNC_STRIP,
        ST_DATA,
        ST_DATA_WAIT,
        ST_EOP_STRIP,
        ST_ERROR,
        ST_ABORT_FULL,
        ST_ABORT_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        BK_DATA,
        BK_STUFF,
        BK_STUFF_ERR
    } bit_kind_e;

    typedef struct packed {
        line_sym_e sym;
        logic      is_level;
        logic      dbit;
    } bit_info_t;

    function automatic logic sym_is_level(line_sym_e s);
        return (s == SYM_J) || (s == SYM_K);
    endfunction

    function automatic logic state_in_packet(rx_state_e s);
        return (s == ST_SYNC_STRIP) || (s == ST_DATA) || (s == ST_DATA_WAIT);
    endfunction

    function automatic logic state_drives_active(rx_state_e s);
        return state_in_packet(s) || (s == ST_ABORT_HOLD);
    endfunction

endpackage

// File: rtl/usbrx_line_if.sv
module usbrx_line_if
    import usbrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       line_dp,
    input  logic       line_dm,
    output logic [1:0] line_state,
    output bit_info_t  info
);
    logic prev_lvl;
    line_sym_e sym;

    assign sym           = line_sym_e'({line_dm, line_dp});
    assign info.sym      = sym;
    assign info.is_level = sym_is_level(sym);
    assign info.dbit     = info.is_level && (line_dp == prev_lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl   <= 1'b1;
            line_state <= SYM_J;
        end else if (bit_en) begin
            line_state <= {line_dm, line_dp};
            prev_lvl   <= info.is_level ? line_dp : 1'b1;
        end
    end
endmodule

// File: rtl/usbrx_sync_det.sv
module usbrx_sync_det #(
    parameter int TAIL = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hunting,
    input  logic bit_en,
    input  logic is_level,
    input  logic dbit,
    output logic hit
);
    localparam logic [TAIL-1:0] PAT = TAIL'(1);

    logic [TAIL-1:0] hist;
    logic [TAIL-1:0] nxt;

    assign nxt = {hist[TAIL-2:0], dbit};
    assign hit = hunting && bit_en && is_level && (nxt == PAT);

    always_ff @(posedge clk) begin
        if (rst || !hunting) begin
            hist <= '1;
        end else if (bit_en) begin
            hist <= is_level ? nxt : '1;
        end
    end
endmodule

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff
    import usbrx_pkg::*;
#(
    parameter int RUN = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load_sync,
    input  logic      step,
    input  logic      dbit,
    output bit_kind_e kind
);
    localparam int ONES_W = $clog2(RUN + 1);

    logic [ONES_W-1:0] ones;

    always_comb begin
        if (ones == ONES_W'(RUN)) begin
            kind = dbit ? BK_STUFF_ERR : BK_STUFF;
        end else begin
            kind = BK_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones <= '0;
        end else if (load_sync) begin
            ones <= ONES_W'(1);
        end else if (step) begin
            if (kind == BK_DATA && dbit) begin
                ones <= ones + 1'b1;
            end else begin
                ones <= '0;
            end
        end
    end
endmodule

// File: rtl/usbrx_byte_asm.sv
module usbrx_byte_asm #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         dbit,
    output logic         boundary,
    output logic         done,
    output logic [W-1:0] hold
);
    localparam int CNT_W = $clog2(W);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     shreg;
    logic [W-1:0]     shnext;

    assign shnext   = {dbit, shreg[W-1:1]};
    assign boundary = (cnt == '0);
    assign done     = shift_en && (cnt == CNT_W'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            shreg <= '0;
            hold  <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (shift_en) begin
            shreg <= shnext;
            if (done) begin
                cnt  <= '0;
                hold <= shnext;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_fs_rx_deser.sv
module usb_fs_rx_deser
    import usbrx_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int STUFF_RUN   = 6,
    parameter int SYNC_TAIL   = 4,
    parameter int EOP_SE0_MIN = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              line_dp,
    input  logic              line_dm,
    output logic [1:0]        line_state,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_active,
    output logic              rx_valid,
    output logic              rx_error
);
    localparam int EOP_CW = $clog2(EOP_SE0_MIN + 1);

    rx_state_e   state, nxt;
    logic [EOP_CW-1:0] eop_cnt, eop_nxt;
    bit_info_t   info;
    bit_kind_e   kind;
    logic        sync_hit, in_pkt, boundary, byte_done, shift_en, stuff_step;

    assign in_pkt     = state_in_packet(state);
    assign stuff_step = bit_en && in_pkt && info.is_level;
    assign shift_en   = stuff_step && (kind == BK_DATA);

    usbrx_line_if u_line (
        .clk(clk), .rst(rst), .bit_en(bit_en),
        .line_dp(line_dp), .line_dm(line_dm),
        .line_state(line_state), .info(info)
    );

    usbrx_sync_det #(.TAIL(SYNC_TAIL)) u_sync (
        .clk(clk), .rst(rst), .hunting(state == ST_HUNT), .bit_en(bit_en),
        .is_level(info.is_level), .dbit(info.dbit), .hit(sync_hit)
    );

    usbrx_unstuff #(.RUN(STUFF_RUN)) u_unstuff (
        .clk(clk), .rst(rst), .load_sync(sync_hit), .step(stuff_step),
        .dbit(info.dbit), .kind(kind)
    );

    usbrx_byte_asm #(.W(BYTE_W)) u_asm (
        .clk(clk), .rst(rst), .clear(!in_pkt), .shift_en(shift_en),
        .dbit(info.dbit), .boundary(boundary), .done(byte_done), .hold(rx_data)
    );

    always_comb begin
        nxt     = state;
        eop_nxt = eop_cnt;
        unique case (state)
            ST_HUNT: begin
                if (sync_hit) nxt = ST_SYNC_STRIP;
            end
            ST_SYNC_STRIP, ST_DATA, ST_DATA_WAIT: begin
                if (info.is_level) begin
                    unique case (kind)
                        BK_DATA: begin
                            if (byte_done || state == ST_DATA_WAIT) nxt = ST_DATA;
                        end
                        BK_STUFF:     nxt = ST_DATA_WAIT;
                        BK_STUFF_ERR: nxt = ST_ERROR;
                        default:      nxt = ST_ERROR;
                    endcase
                end else if (info.sym == SYM_SE0 && boundary) begin
                    nxt     = ST_EOP_STRIP;
                    eop_nxt = EOP_CW'(1);
                end else begin
                    nxt = ST_ERROR;
                end
            end
            ST_EOP_STRIP: begin
                if (info.sym == SYM_SE0) begin
                    if (eop_cnt != EOP_CW'(EOP_SE0_MIN)) eop_nxt = eop_cnt + 1'b1;
                end else if (info.sym == SYM_J && eop_cnt == EOP_CW'(EOP_SE0_MIN)) begin
                    nxt = ST_HUNT;
                end else begin
                    nxt = ST_ERROR;
                end
            end
            ST_ERROR: begin
                if (!rx_active || info.sym == SYM_SE0) nxt = ST_ABORT_FULL;
                else                                   nxt = ST_ABORT_HOLD;
            end
            ST_ABORT_HOLD: begin
                if (info.sym == SYM_SE0) nxt = ST_ABORT_FULL;
            end
            ST_ABORT_FULL: begin
                if (info.sym == SYM_J) nxt = ST_HUNT;
            end
            default: nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            eop_cnt   <= '0;
            rx_active <= 1'b0;
            rx_error  <= 1'b0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= byte_done;
            if (bit_en) begin
                state    <= nxt;
                eop_cnt  <= eop_nxt;
                rx_error <= (nxt == ST_ERROR);
                if (nxt != ST_ERROR) rx_active <= state_drives_active(nxt);
            end
        end
    end
endmodule

// File: rtl/usb_fs_rx_deser_chk.sv
module usb_fs_rx_deser_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_en,
    input logic              line_dp,
    input logic              line_dm,
    input logic [1:0]        line_state,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_active,
    input logic              rx_valid,
    input logic              rx_error
);
    p_valid_in_pkt_r11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_active);

    p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(bit_en));

    p_line_follow_r1: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> line_state == $past({line_dm, line_dp}));

    p_quiet_hold_r13: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_state) && $stable(rx_data)
                    && $stable(rx_active) && $stable(rx_error));

    p_error_one_bit_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_error && bit_en) |=> !rx_error);
endmodule

bind usb_fs_rx_deser usb_fs_rx_deser_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_dp(line_dp), .line_dm(line_dm),
    .line_state(line_state), .rx_data(rx_data), .rx_active(rx_active),
    .rx_valid(rx_valid), .rx_error(rx_error)
);

// File: tb/usb_fs_rx_deser_tb.sv
`timescale 1ns/1ps
module usb_fs_rx_deser_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       line_dp = 1'b1;
    logic       line_dm = 1'b0;
    logic [1:0] line_state;
    logic [7:0] rx_data;
    logic       rx_active, rx_valid, rx_error;

    usb_fs_rx_deser u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .line_dp(line_dp), .line_dm(line_dm),
        .line_state(line_state), .rx_data(rx_data), .rx_active(rx_active),
        .rx_valid(rx_valid), .rx_error(rx_error)
    );

    always #5 clk = ~clk;

    int    n_checks = 0;
    int    n_err    = 0;
    string cur_req  = "R12";
    bit    started  = 0;
    bit    finished = 0;
    bit    tb_lvl   = 1;
    byte unsigned got[$];

    // reference model state
    localparam int P_HUNT = 0, P_PKT = 1, P_EOP = 2, P_ERR = 3, P_WAITJ = 4, P_WAITSE0 = 5;
    int m_phase, m_prev, m_ones, m_nb, m_acc, m_se0;
    int h[$];
    int e_ls, e_data, e_act, e_val, e_err;

    task automatic model_reset();
        m_phase = P_HUNT; m_prev = 1; m_ones = 0; m_nb = 0; m_acc = 0; m_se0 = 0;
        h.delete();
        e_ls = 1; e_data = 0; e_act = 0; e_val = 0; e_err = 0;
    endtask

    task automatic model_step(int s, int dp);
        bit lvl_ok;
        int d;
        lvl_ok = (s == 1) || (s == 2);
        d = (lvl_ok && dp == m_prev) ? 1 : 0;
        e_ls = s;
        case (m_phase)
            P_HUNT: begin
                if (lvl_ok) begin
                    h.push_back(d);
                    if (h.size() > 4) void'(h.pop_front());
                    if (h.size() == 4 && h[0] == 0 && h[1] == 0 && h[2] == 0 && h[3] == 1) begin
                        m_phase = P_PKT; e_act = 1; m_ones = 1; m_nb = 0; m_acc = 0;
                        h.delete();
                    end
                end else h.delete();
            end
            P_PKT: begin
                if (lvl_ok) begin
                    if (m_ones == 6) begin
                        if (d == 1) begin m_phase = P_ERR; e_err = 1; end
                        else m_ones = 0;
                    end else begin
                        m_acc = m_acc + (d << m_nb);
                        m_nb++;
                        m_ones = d ? m_ones + 1 : 0;
                        if (m_nb == 8) begin
                            e_data = m_acc; e_val = 1; m_nb = 0; m_acc = 0;
                        end
                    end
                end else if (s == 0 && m_nb == 0) begin
                    m_phase = P_EOP; e_act = 0; m_se0 = 1;
                end else begin
                    m_phase = P_ERR; e_err = 1;
                end
            end
            P_EOP: begin
                if (s == 0) m_se0++;
                else if (s == 1 && m_se0 >= 2) m_phase = P_HUNT;
                else begin m_phase = P_ERR; e_err = 1; end
            end
            P_ERR: begin
                e_err = 0;
                if (e_act == 0 || s == 0) begin m_phase = P_WAITJ; e_act = 0; end
                else m_phase = P_WAITSE0;
            end
            P_WAITSE0: if (s == 0) begin m_phase = P_WAITJ; e_act = 0; end
            P_WAITJ:   if (s == 1) m_phase = P_HUNT;
            default:   m_phase = P_HUNT;
        endcase
        m_prev = lvl_ok ? dp : 1;
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            e_val = 0;
            if (bit_en) model_step({line_dm, line_dp}, line_dp);
        end
        started = 1;
    end

    task automatic chk(bit ok, string tag, string nm, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t", tag, cur_req, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk(line_state == e_ls[1:0], "R1", "line_state", line_state, e_ls);
            chk(rx_active == e_act[0], "R3", "rx_active", rx_active, e_act);
            chk(rx_valid == e_val[0], "R4", "rx_valid", rx_valid, e_val);
            chk(rx_error == e_err[0], "R6", "rx_error", rx_error, e_err);
            chk(rx_data == e_data[7:0], "R4", "rx_data", rx_data, e_data);
            if (rx_valid) got.push_back(rx_data);
        end
    end

    task automatic drive(logic [1:0] s, int gap);
        line_dm = s[1]; line_dp = s[0]; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_bit(bit d, int gap);
        if (!d) tb_lvl = !tb_lvl;
        drive(tb_lvl ? 2'b01 : 2'b10, gap);
    endtask

    task automatic send_sync(int gap);
        for (int i = 0; i < 7; i++) send_bit(1'b0, gap);
        send_bit(1'b1, gap);
    endtask

    task automatic send_eop(int gap);
        drive(2'b00, gap); drive(2'b00, gap); drive(2'b01, gap);
        tb_lvl = 1;
    endtask

    task automatic send_packet(byte unsigned b[$], int gap, bit final_stuff);
        int ones;
        bit last;
        send_sync(gap);
        ones = 1;
        for (int k = 0; k < b.size(); k++) begin
            for (int i = 0; i < 8; i++) begin
                last = (k == b.size() - 1) && (i == 7);
                send_bit(b[k][i], gap);
                ones = b[k][i] ? ones + 1 : 0;
                if (ones == 6) begin
                    if (!last || final_stuff) send_bit(1'b0, gap);
                    ones = 0;
                end
            end
        end
        send_eop(gap);
    endtask

    task automatic check_bytes(byte unsigned exp[$]);
        repeat (3) @(negedge clk);
        chk(got.size() == exp.size(), "R4", "byte count", got.size(), exp.size());
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            chk(got[i] == exp[i], "R4", "byte value", got[i], exp[i]);
        got.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values
        chk(rx_active == 0 && rx_valid == 0 && rx_error == 0 && rx_data == 8'h00,
            "R12", "reset outputs", {rx_active, rx_valid, rx_error}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R13: idle symbols and SE1 while hunting, gaps between strobes
        cur_req = "R1 R13";
        drive(2'b01, 3); drive(2'b11, 2); drive(2'b01, 2); drive(2'b10, 1); drive(2'b01, 2);
        tb_lvl = 1;
        check_bytes('{});

        // R3: a SYNC tail cut by SE0 must not open a packet
        cur_req = "R3";
        send_bit(0, 1); send_bit(0, 1); send_bit(0, 1);
        drive(2'b00, 1); drive(2'b01, 1); tb_lvl = 1;
        check_bytes('{});

        // R2 R3 R4 R7: plain packet
        cur_req = "R2 R3 R4 R7";
        send_packet('{8'hC3, 8'hA5}, 3, 1);
        check_bytes('{8'hC3, 8'hA5});

        // R5: long runs of 1s with stuffed zeros
        cur_req = "R5";
        send_packet('{8'hFF, 8'h7F, 8'h00}, 1, 1);
        check_bytes('{8'hFF, 8'h7F, 8'h00});

        // R5 R7: byte ends with six 1s, stuffed zero sent
        cur_req = "R5 R7";
        send_packet('{8'hFC}, 2, 1);
        check_bytes('{8'hFC});

        // R7: SE0 lands in the pending stuff position
        cur_req = "R7";
        send_packet('{8'hFC}, 2, 0);
        check_bytes('{8'hFC});

        // R4: back-to-back strobes
        cur_req = "R4";
        send_packet('{8'h5A, 8'h0F, 8'hF0}, 0, 1);
        check_bytes('{8'h5A, 8'h0F, 8'hF0});

        // R6 R10: stuffing violation, packet flag held until SE0
        cur_req = "R6 R10";
        send_sync(1);
        for (int i = 0; i < 6; i++) send_bit(1'b1, 1);
        send_bit(1'b0, 1); send_bit(1'b1, 1);
        drive(2'b00, 1); drive(2'b00, 1); drive(2'b01, 1); tb_lvl = 1;
        check_bytes('{});

        // R8 R10: SE0 mid-byte, then SE0 gives the full abort
        cur_req = "R8 R10";
        send_sync(2);
        send_bit(1, 2); send_bit(0, 2); send_bit(1, 2);
        drive(2'b00, 2); drive(2'b00, 2); drive(2'b10, 2); drive(2'b01, 2); tb_lvl = 1;
        check_bytes('{});

        // R8: SE1 at a byte boundary inside a packet
        cur_req = "R8 R10";
        send_sync(1);
        drive(2'b11, 1); drive(2'b10, 1); drive(2'b01, 1);
        drive(2'b00, 1); drive(2'b01, 1); tb_lvl = 1;
        check_bytes('{});

        // R9: J after a single SE0
        cur_req = "R9";
        send_sync(1);
        for (int i = 0; i < 8; i++) send_bit(1'b0, 1);
        drive(2'b00, 1); drive(2'b01, 1); drive(2'b01, 1); drive(2'b01, 1); tb_lvl = 1;
        check_bytes('{8'h00});

        // R11 R4: recovery after the error cases
        cur_req = "R11 R4";
        send_packet('{8'h12, 8'h34}, 2, 1);
        check_bytes('{8'h12, 8'h34});

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_err++;
            $display("FAIL watchdog (%s): actual running expected done", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule